// File: doc/BRIEF.md
# Multi-Lag Correlator with Parallel Dump Register

This block forms lagged correlation products between two streams of small signed samples, taking one sample pair per clock when the valid input is high. Each lag has its own saturating accumulator. Lag k adds the product of the current stream-A sample and a source sample taken k valid samples earlier. The source is either stream A itself (autocorrelation) or stream B (cross-correlation). A short delay line supplies the earlier source samples.

An interval-end strobe closes the sample interval. In a single clock edge, every accumulator is copied into a shift register of the same length and cleared. The shift register then presents one lag per clock on the dump port, together with the lag index and a valid flag. Accumulation of the next interval carries on while the dump is read out.

The dump length follows the number of lags in use, so the shortest usable interval shrinks with it. A strobe that arrives while a dump still has more than one lag to deliver is refused and flagged. The lag count is a parameter: sizes up to 1024 lags of 32-bit accumulators are intended. The default is kept small.

Top module: `xcorr_engine`

## Requirements
- R1: After reset, `dumpValid`, `overrun` and `dumpData` are 0, and every accumulator and every delay-line stage holds 0.
- R2: In a cycle with `sampleValid`=1, each enabled lag k adds A×S(k) to its accumulator. A is the signed two's-complement `sampleA`, and S(k) is the source sample from k valid samples earlier, with S(0) the current one. In a cycle with `sampleValid`=0, no accumulator and no delay stage changes.
- R3: An accepted `intervalEnd` copies all accumulators into the dump register and clears them at the same edge. A sample valid in that same cycle counts toward the new interval only.
- R4: After an accepted strobe, `dumpValid` is high for exactly L consecutive cycles, beginning the cycle after the strobe edge. `dumpLag` runs 0,1,…,L-1 in ascending order and `dumpData` carries the copied value of that lag. L is the effective lag count at the moment of acceptance.
- R5: Accumulation continues during readout. A strobe given in the cycle where the last lag (L-1) is on the port is accepted, so intervals as short as L cycles are possible.
- R6: A strobe given while more than one lag is left to deliver raises `overrun` for exactly the next cycle. It neither copies nor clears the accumulators, and the readout in progress is unaffected.
- R7: Accumulators saturate at the signed limits of their width (+2^(W-1)-1 and -2^(W-1)) instead of wrapping.
- R8: `crossMode`=0 selects `sampleA` as the delayed source (autocorrelation). `crossMode`=1 selects `sampleB` (cross-correlation). The delay line stores whichever source is selected when each sample enters it.
- R9: Only lags k < L accumulate, with L = `lagCount`. A `lagCount` of 0, or one above NUM_LAGS, means NUM_LAGS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleA | input | SAMPLE_W | Stream A sample, signed |
| sampleB | input | SAMPLE_W | Stream B sample, signed |
| sampleValid | input | 1 | Sample pair present this cycle |
| crossMode | input | 1 | 1 = cross-correlation, 0 = autocorrelation |
| lagCount | input | $clog2(NUM_LAGS+1) | Number of lags in use |
| intervalEnd | input | 1 | Close the current sample interval |
| dumpData | output | ACC_W | Dumped accumulator value |
| dumpLag | output | $clog2(NUM_LAGS) | Lag index of `dumpData` |
| dumpValid | output | 1 | Dump word present |
| overrun | output | 1 | Previous cycle's strobe was refused |

## Verification
A strobe sampled at clock edge n puts lag 0 on the dump port just after edge n, and lag i just after edge n+i. An overrun pulse likewise follows the refused strobe's edge by one edge. The bench drives every input at the falling edge and keeps a reference model that it advances once per rising edge. It compares valid, lag index, data and overrun at each following falling edge, so every comparison lands on the first cycle in which a result is due.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;
  // strobes from the interval controller to the datapath
  typedef struct packed {
    logic load;      // copy accumulators into dump register, clear them
    logic shift;     // advance the dump register by one lag
    logic sampleEn;  // accumulate the current sample pair
  } ctl_t;
endpackage

// File: rtl/xcorr_ctrl.sv
module xcorr_ctrl
  import xcorr_pkg::*;
#(
  parameter int NUM_LAGS = 16,
  localparam int LAG_W = (NUM_LAGS > 1) ? $clog2(NUM_LAGS) : 1,
  localparam int CNT_W = $clog2(NUM_LAGS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             intervalEnd,
  input  logic [CNT_W-1:0] lagCount,
  output logic [CNT_W-1:0] activeLags,
  output ctl_t             ctl,
  output logic             dumpValid,
  output logic [LAG_W-1:0] dumpLag,
  output logic             overrun
);
  localparam logic [CNT_W-1:0] MAX_LAGS = CNT_W'(NUM_LAGS);

  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] lenR;
  logic [LAG_W-1:0] lagR;
  logic             overrunR;
  logic             accept;

  always_comb begin
    if (lagCount == '0 || lagCount > MAX_LAGS) activeLags = MAX_LAGS;
    else                                       activeLags = lagCount;
  end

  // a strobe is taken when the register is idle or on its last lag
  assign accept       = intervalEnd && (remaining <= CNT_W'(1));
  assign ctl.load     = accept;
  assign ctl.shift    = (remaining != '0);
  assign ctl.sampleEn = sampleValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
      lenR      <= '0;
      lagR      <= '0;
      overrunR  <= 1'b0;
    end else begin
      overrunR <= intervalEnd && !accept;
      if (accept) begin
        remaining <= activeLags;
        lenR      <= activeLags;
        lagR      <= '0;
      end else if (remaining != '0) begin
        remaining <= remaining - CNT_W'(1);
        lagR      <= lagR + LAG_W'(1);
      end
    end
  end

  assign dumpValid = (remaining != '0);
  assign dumpLag   = lagR;
  assign overrun   = overrunR;

  AST_STROBE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    intervalEnd |=> (overrun || (dumpValid && dumpLag == '0))); // R6
  AST_LAG_ASCENDS: assert property (@(posedge clk) disable iff (!rstN)
    (remaining > CNT_W'(1)) |=> (dumpLag == $past(dumpLag) + LAG_W'(1))); // R4
  AST_LAG_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    dumpValid |-> (CNT_W'(dumpLag) < lenR)); // R4
  AST_OVR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> $past(intervalEnd)); // R6
endmodule

// File: rtl/xcorr_datapath.sv
module xcorr_datapath
  import xcorr_pkg::*;
#(
  parameter int NUM_LAGS = 16,
  parameter int SAMPLE_W = 4,
  parameter int ACC_W    = 32,
  localparam int CNT_W   = $clog2(NUM_LAGS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_t                ctl,
  input  logic                crossMode,
  input  logic [SAMPLE_W-1:0] sampleA,
  input  logic [SAMPLE_W-1:0] sampleB,
  input  logic [CNT_W-1:0]    activeLags,
  output logic [ACC_W-1:0]    dumpData
);
  localparam int PROD_W = 2 * SAMPLE_W;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [SAMPLE_W-1:0] src;
  logic signed [SAMPLE_W-1:0] hist [1:NUM_LAGS-1];
  logic signed [SAMPLE_W-1:0] tap  [NUM_LAGS];
  logic signed [PROD_W-1:0]   prod [NUM_LAGS];
  logic signed [ACC_W-1:0]    acc  [NUM_LAGS];
  logic signed [ACC_W-1:0]    accNext [NUM_LAGS];
  logic        [ACC_W-1:0]    shReg [NUM_LAGS];

  assign src = crossMode ? $signed(sampleB) : $signed(sampleA);

  // products and saturating sums, one per lag
  always_comb begin
    logic signed [PROD_W-1:0] aX;
    logic signed [PROD_W-1:0] tX;
    logic signed [ACC_W-1:0]  base;
    logic signed [ACC_W:0]    sumW;
    aX = PROD_W'($signed(sampleA));
    tap[0] = src;
    for (int k = 1; k < NUM_LAGS; k++) tap[k] = hist[k];
    for (int k = 0; k < NUM_LAGS; k++) begin
      tX      = PROD_W'(tap[k]);
      prod[k] = aX * tX;
      base    = ctl.load ? '0 : acc[k];
      sumW    = (ACC_W+1)'(base) + (ACC_W+1)'(prod[k]);
      if (ctl.sampleEn && (CNT_W'(k) < activeLags)) begin
        if (sumW[ACC_W] != sumW[ACC_W-1]) accNext[k] = sumW[ACC_W] ? ACC_MIN : ACC_MAX;
        else                              accNext[k] = sumW[ACC_W-1:0];
      end else begin
        accNext[k] = base;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 1; k < NUM_LAGS; k++) hist[k] <= '0;
    end else if (ctl.sampleEn) begin
      hist[1] <= src;
      for (int k = 2; k < NUM_LAGS; k++) hist[k] <= hist[k-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_LAGS; k++) acc[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_LAGS; k++) acc[k] <= accNext[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_LAGS; k++) shReg[k] <= '0;
    end else if (ctl.load) begin
      for (int k = 0; k < NUM_LAGS; k++) shReg[k] <= acc[k];
    end else if (ctl.shift) begin
      for (int k = 0; k < NUM_LAGS-1; k++) shReg[k] <= shReg[k+1];
      shReg[NUM_LAGS-1] <= '0;
    end
  end

  assign dumpData = shReg[0];

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.sampleEn) |=> $stable(acc[0])); // R2
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (dumpData == $past(acc[0]))); // R3
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (acc[0] == ACC_MAX && ctl.sampleEn && !ctl.load && prod[0] >= 0) |=> (acc[0] == ACC_MAX)); // R7
  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rstN)
    (acc[0] == ACC_MIN && ctl.sampleEn && !ctl.load && prod[0] <= 0) |=> (acc[0] == ACC_MIN)); // R7
endmodule

// File: rtl/xcorr_engine.sv
module xcorr_engine
  import xcorr_pkg::*;
#(
  parameter int NUM_LAGS = 16,
  parameter int SAMPLE_W = 4,
  parameter int ACC_W    = 32,
  localparam int LAG_W = (NUM_LAGS > 1) ? $clog2(NUM_LAGS) : 1,
  localparam int CNT_W = $clog2(NUM_LAGS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleA,
  input  logic [SAMPLE_W-1:0] sampleB,
  input  logic                sampleValid,
  input  logic                crossMode,
  input  logic [CNT_W-1:0]    lagCount,
  input  logic                intervalEnd,
  output logic [ACC_W-1:0]    dumpData,
  output logic [LAG_W-1:0]    dumpLag,
  output logic                dumpValid,
  output logic                overrun
);
  ctl_t             ctl;
  logic [CNT_W-1:0] activeLags;

  xcorr_ctrl #(.NUM_LAGS(NUM_LAGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .intervalEnd(intervalEnd),
    .lagCount(lagCount), .activeLags(activeLags), .ctl(ctl),
    .dumpValid(dumpValid), .dumpLag(dumpLag), .overrun(overrun)
  );

  xcorr_datapath #(.NUM_LAGS(NUM_LAGS), .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .crossMode(crossMode),
    .sampleA(sampleA), .sampleB(sampleB), .activeLags(activeLags), .dumpData(dumpData)
  );
endmodule

// File: tb/test_xcorr_engine.sv
module test_xcorr_engine;
  localparam int NL = 8;
  localparam int SW = 4;
  localparam int AW = 12;
  localparam int LW = $clog2(NL);
  localparam int CW = $clog2(NL + 1);
  localparam int AMAX = (1 << (AW-1)) - 1;
  localparam int AMIN = -(1 << (AW-1));

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [SW-1:0] sampleA = '0, sampleB = '0;
  logic          sampleValid = 1'b0, crossMode = 1'b0, intervalEnd = 1'b0;
  logic [CW-1:0] lagCount = CW'(NL);
  logic [AW-1:0] dumpData;
  logic [LW-1:0] dumpLag;
  logic          dumpValid, overrun;

  always #4 clk = ~clk;

  xcorr_engine #(.NUM_LAGS(NL), .SAMPLE_W(SW), .ACC_W(AW)) i_xcorr_engine (
    .clk(clk), .rstN(rstN), .sampleA(sampleA), .sampleB(sampleB),
    .sampleValid(sampleValid), .crossMode(crossMode), .lagCount(lagCount),
    .intervalEnd(intervalEnd), .dumpData(dumpData), .dumpLag(dumpLag),
    .dumpValid(dumpValid), .overrun(overrun)
  );

  int total = 0, bad = 0, cycles = 0;
  string curTag = "R1";
  // reference model state
  int refHist [NL];
  int refAcc  [NL];
  int snap    [NL];
  int refRem = 0, expLag = 0;
  bit expOvr = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", curTag, what, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > AMAX) return AMAX;
    if (v < AMIN) return AMIN;
    return v;
  endfunction

  // one clock: drive at falling edge, advance model, check at next falling edge
  task automatic step(input int a, input int b, input bit v, input bit ie);
    int eff, src, tapv;
    bit acc_ok;
    sampleA = SW'(a); sampleB = SW'(b); sampleValid = v; intervalEnd = ie;
    eff = (int'(lagCount) == 0 || int'(lagCount) > NL) ? NL : int'(lagCount);
    acc_ok = ie && (refRem <= 1);
    if (acc_ok) begin
      for (int k = 0; k < NL; k++) begin snap[k] = refAcc[k]; refAcc[k] = 0; end
      refRem = eff; expLag = 0;
    end else if (refRem > 0) begin
      refRem--; expLag++;
    end
    expOvr = ie && !acc_ok;
    if (v) begin
      src = crossMode ? b : a;
      for (int k = 0; k < eff; k++) begin
        tapv = (k == 0) ? src : refHist[k];
        refAcc[k] = sat(refAcc[k] + a * tapv);
      end
      for (int k = NL-1; k > 1; k--) refHist[k] = refHist[k-1];
      refHist[1] = src;
    end
    @(negedge clk);
    chk(dumpValid == (refRem != 0), "dumpValid", int'(dumpValid), int'(refRem != 0));
    chk(overrun == expOvr, "overrun", int'(overrun), int'(expOvr));
    if (refRem != 0 && dumpValid) begin
      chk(int'(dumpLag) == expLag, "dumpLag", int'(dumpLag), expLag);
      chk(int'($signed(dumpData)) == snap[expLag], "dumpData", int'($signed(dumpData)), snap[expLag]);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic test_reset();
    curTag = "R1";
    chk(dumpValid == 0, "dumpValid after reset", int'(dumpValid), 0);
    chk(overrun == 0, "overrun after reset", int'(overrun), 0);
    chk(dumpData == '0, "dumpData after reset", int'(dumpData), 0);
    step(0, 0, 0, 1);   // dump of untouched accumulators must be all zero
    idle(NL + 1);
  endtask

  task automatic test_auto();
    curTag = "R2 R3 R4 auto";
    crossMode = 0; lagCount = CW'(NL);
    for (int i = 0; i < 12; i++) step((i % 5) - 2, 0, 1, 0);
    step(3, 0, 1, 1);   // sample in strobe cycle belongs to next interval (R3)
    idle(NL + 2);
    chk(dumpValid == 0, "R4 dump ended", int'(dumpValid), 0);
    step(0, 0, 0, 1);
    idle(NL + 1);
  endtask

  task automatic test_cross();
    curTag = "R8 R2 cross with gaps";
    crossMode = 1;
    for (int i = 0; i < 14; i++) step(7 - i, (i * 3) % 16 - 8, (i % 3) != 1, 0);
    step(0, 0, 0, 1);
    idle(NL + 1);
  endtask

  task automatic test_lagcount();
    curTag = "R9 lag count 3";
    lagCount = CW'(3); crossMode = 0;
    for (int i = 0; i < 9; i++) step(i - 4, 0, 1, 0);
    step(0, 0, 0, 1);
    idle(5);
    curTag = "R9 lag count 0 means all";
    lagCount = '0;
    for (int i = 0; i < 9; i++) step(5 - i, 0, 1, 0);
    step(0, 0, 0, 1);
    idle(NL + 1);
    lagCount = CW'(NL);
  endtask

  task automatic test_overlap();
    curTag = "R5 back-to-back";
    crossMode = 1;
    for (int i = 0; i < 6; i++) step(i - 3, 2 - i, 1, 0);
    step(1, -1, 1, 1);
    while (refRem != 1) step(2, 3, 1, 0);
    step(-2, 4, 1, 1);  // strobe on last lag: accepted
    chk(dumpValid == 1 && dumpLag == '0, "R5 restart on last lag", int'(dumpLag), 0);
    idle(NL + 1);
  endtask

  task automatic test_overrun();
    curTag = "R6 overrun";
    crossMode = 0;
    for (int i = 0; i < 5; i++) step(i + 1, 0, 1, 0);
    step(2, 0, 1, 1);
    step(3, 0, 1, 0);
    step(-1, 0, 1, 1);  // refused: readout continues, accumulators kept
    chk(overrun == 1, "R6 overrun pulse", int'(overrun), 1);
    step(4, 0, 1, 0);
    chk(overrun == 0, "R6 overrun one cycle", int'(overrun), 0);
    idle(NL);
    step(0, 0, 0, 1);
    idle(NL + 1);
  endtask

  task automatic test_saturation();
    curTag = "R7 positive saturation";
    crossMode = 0;
    for (int i = 0; i < 50; i++) step(7, 0, 1, 0);
    step(0, 0, 0, 1);
    chk(int'($signed(dumpData)) == AMAX, "R7 lag0 at max", int'($signed(dumpData)), AMAX);
    idle(NL + 1);
    curTag = "R7 negative saturation";
    crossMode = 1;
    for (int i = 0; i < 50; i++) step(7, -8, 1, 0);
    step(0, 0, 0, 1);
    chk(int'($signed(dumpData)) == AMIN, "R7 lag0 at min", int'($signed(dumpData)), AMIN);
    idle(NL + 1);
  endtask

  initial begin
    for (int k = 0; k < NL; k++) begin refHist[k] = 0; refAcc[k] = 0; snap[k] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_auto();
    test_cross();
    test_lagcount();
    test_overlap();
    test_overrun();
    test_saturation();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog all requirements: actual=%0d cycles expected=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule